// File: doc/BRIEF.md
# Tagged Translation Lookaside Buffer

This block is a small fully associative cache of page translations. It serves several guests and several processes inside each guest at once. Every entry is tagged with a virtual machine number and an address space number. A lookup matches an entry only when both tags equal the current ones, so a context switch or a guest switch needs no flush. Each entry maps either a 4 KB page or a 2 MB block. The entry's size sets how many page-number bits take part in the compare and how many offset bits pass straight into the physical address.

A lookup presents a virtual address, the two identifiers and an access kind. On a hit the block answers one cycle later with the physical address and a permission verdict. On a miss it stops taking lookups and raises a walk request carrying the missed address and tags. It then waits for the external walker to return a refill. The refill holds the frame number, the size, and the permission sets of both translation stages. The block stores the bitwise AND of the two sets, writes the entry and answers one cycle after the refill. Invalidations clear the whole array, one guest, or one process of one guest, in a single cycle.

Top module: `vtag_tlb`

## Requirements
- R1: An entry matches only when its stored address space number equals `lk_asid`. Two entries for the same page that differ only in that number coexist and each returns its own frame.
- R2: An entry matches only when its stored virtual machine number equals `lk_vmid`. A lookup from another guest with the same address space number misses.
- R3: A lookup accepted on a miss makes `walk_req` high from the next cycle, with `walk_va`, `walk_asid` and `walk_vmid` equal to the missed request. A hit never raises `walk_req`.
- R4: For a 4 KB entry (`fill_big`=0) the result is the stored 20-bit frame followed by virtual address bits [11:0].
- R5: `rsp_cause` encodes the permission verdict: 0 allowed, 1 read denied, 2 write denied, 3 execute denied. `rsp_fault` is high exactly when the cause is non-zero. `lk_acc` is 0 for read, 1 for write and 2 for instruction fetch; the value 3 is treated as a read.
- R6: Permission sets are 3 bits, with bit 0 read, bit 1 write and bit 2 execute. The stored set is the AND of `fill_perm_s1` and `fill_perm_s2`, and it applies both to the refill's own answer and to later hits.
- R7: For a 2 MB entry (`fill_big`=1), virtual address bits [20:12] are excluded from the compare. The result is frame bits [19:9] followed by virtual address bits [20:0]. An address just past the block misses.
- R8: A refill writes the lowest-numbered invalid entry. When all entries are valid it writes the entry at a round-robin pointer, which starts at 0 after reset and advances by one after each such eviction.
- R9: With `inv_valid` high, `inv_kind` 0 clears all entries, 1 clears entries whose guest tag equals `inv_vmid`, and 2 clears entries matching both `inv_vmid` and `inv_asid`. The clear takes effect for the next lookup, and other entries are kept.
- R10: A hit answers with `rsp_valid` one cycle after acceptance. After a miss, `lk_ready` stays low and no answer appears until `fill_valid` arrives. The answer comes one cycle after the refill, and `lk_ready` returns high in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_ready | output | 1 | Lookup accepted when high |
| lk_va | input | 32 | Virtual address |
| lk_asid | input | 8 | Current address space number |
| lk_vmid | input | 4 | Current virtual machine number |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 fetch) |
| rsp_valid | output | 1 | Result valid |
| rsp_pa | output | 32 | Physical address |
| rsp_fault | output | 1 | Permission fault |
| rsp_cause | output | 2 | Fault cause code |
| walk_req | output | 1 | Miss outstanding, walk needed |
| walk_va | output | 32 | Missed virtual address |
| walk_asid | output | 8 | Missed address space number |
| walk_vmid | output | 4 | Missed virtual machine number |
| fill_valid | input | 1 | Refill response |
| fill_ppn | input | 20 | Refill frame number |
| fill_big | input | 1 | Refill size (0 = 4 KB, 1 = 2 MB) |
| fill_perm_s1 | input | 3 | First-stage permissions |
| fill_perm_s2 | input | 3 | Second-stage permissions |
| inv_valid | input | 1 | Invalidate command |
| inv_kind | input | 2 | 0 all, 1 by guest, 2 by guest and process |
| inv_vmid | input | 4 | Guest selector for invalidate |
| inv_asid | input | 8 | Process selector for invalidate |

## Verification
The bench places the same page under two process numbers and then under two guests. A design that left either tag out of the compare would return the other context's frame. A 2 MB entry is probed at its last word and at the first address past it: a wrong mask either misses inside the block or aliases the next region. The refill permissions are chosen so that only their intersection grants read, so a design that kept one stage's set would let a write or fetch through. The array is filled and then overrun twice to confirm that the victim moves on. An LRU or fixed victim would evict the wrong page, and the bench sees that as a missing walk or an unexpected one.

// File: rtl/vtag_tlb_pkg.sv
package vtag_tlb_pkg;

  typedef enum logic [1:0] {
    ACC_RD = 2'd0,
    ACC_WR = 2'd1,
    ACC_EX = 2'd2
  } acc_e;

  typedef enum logic [1:0] {
    INV_ALL  = 2'd0,
    INV_VM   = 2'd1,
    INV_VMAS = 2'd2
  } inv_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } tlb_st_e;

  localparam logic [1:0] CAUSE_OK = 2'd0;
  localparam logic [1:0] CAUSE_RD = 2'd1;
  localparam logic [1:0] CAUSE_WR = 2'd2;
  localparam logic [1:0] CAUSE_EX = 2'd3;

  // perm bit 0 read, bit 1 write, bit 2 execute
  function automatic logic [1:0] perm_cause(input logic [2:0] perm, input logic [1:0] acc);
    logic [1:0] c;
    case (acc)
      ACC_WR:  c = perm[1] ? CAUSE_OK : CAUSE_WR;
      ACC_EX:  c = perm[2] ? CAUSE_OK : CAUSE_EX;
      default: c = perm[0] ? CAUSE_OK : CAUSE_RD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/vtag_tlb_entry.sv
module vtag_tlb_entry #(
  parameter int VPN_W  = 20,
  parameter int PPN_W  = 20,
  parameter int SPAN_W = 9,
  parameter int VMID_W = 4,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  input  logic [VMID_W-1:0] lk_vmid,
  output logic              hit,
  output logic              valid_o,
  output logic [PPN_W-1:0]  ppn_o,
  output logic              big_o,
  output logic [2:0]        perm_o,
  input  logic              wr_en,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic [VMID_W-1:0] wr_vmid,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic              wr_big,
  input  logic [2:0]        wr_perm,
  input  logic              inv_en,
  input  logic [1:0]        inv_kind,
  input  logic [VMID_W-1:0] inv_vmid,
  input  logic [ASID_W-1:0] inv_asid
);
  import vtag_tlb_pkg::*;

  logic              valid_q, valid_d;
  logic [VPN_W-1:0]  vpn_q;
  logic [ASID_W-1:0] asid_q;
  logic [VMID_W-1:0] vmid_q;
  logic [PPN_W-1:0]  ppn_q;
  logic              big_q;
  logic [2:0]        perm_q;
  logic [VPN_W-1:0]  cmp_mask;
  logic              inv_match;

  // a 2 MB entry ignores the low SPAN_W page-number bits
  assign cmp_mask = big_q ? {{(VPN_W-SPAN_W){1'b1}}, {SPAN_W{1'b0}}} : {VPN_W{1'b1}};
  assign hit = valid_q && (vmid_q == lk_vmid) && (asid_q == lk_asid) &&
               (((vpn_q ^ lk_vpn) & cmp_mask) == '0);

  always_comb begin
    case (inv_kind)
      INV_ALL:  inv_match = 1'b1;
      INV_VM:   inv_match = (vmid_q == inv_vmid);
      INV_VMAS: inv_match = (vmid_q == inv_vmid) && (asid_q == inv_asid);
      default:  inv_match = 1'b0;
    endcase
    valid_d = valid_q;
    if (inv_en && inv_match) valid_d = 1'b0;
    if (wr_en)               valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vpn_q  <= wr_vpn;
      asid_q <= wr_asid;
      vmid_q <= wr_vmid;
      ppn_q  <= wr_ppn;
      big_q  <= wr_big;
      perm_q <= wr_perm;
    end
  end

  assign valid_o = valid_q;
  assign ppn_o   = ppn_q;
  assign big_o   = big_q;
  assign perm_o  = perm_q;

endmodule

// File: rtl/vtag_tlb_victim.sv
module vtag_tlb_victim #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               alloc,
  output logic [IDX_W-1:0]   slot
);
  logic [IDX_W-1:0] rr_q, rr_d, free_idx;
  logic             any_free;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) free_idx = IDX_W'(i);
    end
    any_free = ~&valid_vec;
    slot     = any_free ? free_idx : rr_q;
    rr_d     = rr_q;
    if (alloc && !any_free) begin
      rr_d = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rr_q <= '0;
    else        rr_q <= rr_d;
  end

  // R8: while a free entry exists, the chosen slot is never a live one
  a_r8_free_slot_first: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && !(&valid_vec)) |-> !valid_vec[slot]);

endmodule

// File: rtl/vtag_tlb.sv
module vtag_tlb #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int BLK_BITS  = 21,
  parameter int ENTRIES   = 8,
  parameter int VMID_W    = 4,
  parameter int ASID_W    = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      lk_valid,
  output logic                      lk_ready,
  input  logic [VA_W-1:0]           lk_va,
  input  logic [ASID_W-1:0]         lk_asid,
  input  logic [VMID_W-1:0]         lk_vmid,
  input  logic [1:0]                lk_acc,
  output logic                      rsp_valid,
  output logic [PA_W-1:0]           rsp_pa,
  output logic                      rsp_fault,
  output logic [1:0]                rsp_cause,
  output logic                      walk_req,
  output logic [VA_W-1:0]           walk_va,
  output logic [ASID_W-1:0]         walk_asid,
  output logic [VMID_W-1:0]         walk_vmid,
  input  logic                      fill_valid,
  input  logic [PA_W-PAGE_BITS-1:0] fill_ppn,
  input  logic                      fill_big,
  input  logic [2:0]                fill_perm_s1,
  input  logic [2:0]                fill_perm_s2,
  input  logic                      inv_valid,
  input  logic [1:0]                inv_kind,
  input  logic [VMID_W-1:0]         inv_vmid,
  input  logic [ASID_W-1:0]         inv_asid
);
  import vtag_tlb_pkg::*;

  localparam int VPN_W  = VA_W - PAGE_BITS;
  localparam int PPN_W  = PA_W - PAGE_BITS;
  localparam int SPAN_W = BLK_BITS - PAGE_BITS;
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  tlb_st_e           st_q, st_d;
  logic [VA_W-1:0]   va_q;
  logic [ASID_W-1:0] asid_q;
  logic [VMID_W-1:0] vmid_q;
  logic [1:0]        acc_q;
  logic              rv_q, rv_d;
  logic [PA_W-1:0]   pa_q, pa_d;
  logic [1:0]        cause_q, cause_d;

  logic [ENTRIES-1:0] hit_vec, valid_vec;
  logic [PPN_W-1:0]   e_ppn  [ENTRIES];
  logic               e_big  [ENTRIES];
  logic [2:0]         e_perm [ENTRIES];

  logic             hit_any, sel_big;
  logic [PPN_W-1:0] sel_ppn;
  logic [2:0]       sel_perm, fill_perm;
  logic             acc_fire, fill_take, cap_en;
  logic [IDX_W-1:0] slot;

  function automatic logic [PA_W-1:0] make_pa(input logic [PPN_W-1:0] ppn,
                                              input logic big, input logic [VA_W-1:0] va);
    return big ? {ppn[PPN_W-1:SPAN_W], va[BLK_BITS-1:0]} : {ppn, va[PAGE_BITS-1:0]};
  endfunction

  assign lk_ready  = (st_q == ST_IDLE);
  assign acc_fire  = lk_valid && lk_ready;
  assign fill_take = (st_q == ST_WAIT) && fill_valid;
  assign fill_perm = fill_perm_s1 & fill_perm_s2;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    vtag_tlb_entry #(
      .VPN_W(VPN_W), .PPN_W(PPN_W), .SPAN_W(SPAN_W), .VMID_W(VMID_W), .ASID_W(ASID_W)
    ) u_ent (
      .clk(clk), .rst_n(rst_n),
      .lk_vpn(lk_va[VA_W-1:PAGE_BITS]), .lk_asid(lk_asid), .lk_vmid(lk_vmid),
      .hit(hit_vec[g]), .valid_o(valid_vec[g]),
      .ppn_o(e_ppn[g]), .big_o(e_big[g]), .perm_o(e_perm[g]),
      .wr_en(fill_take && (slot == IDX_W'(g))),
      .wr_vpn(va_q[VA_W-1:PAGE_BITS]), .wr_asid(asid_q), .wr_vmid(vmid_q),
      .wr_ppn(fill_ppn), .wr_big(fill_big), .wr_perm(fill_perm),
      .inv_en(inv_valid), .inv_kind(inv_kind), .inv_vmid(inv_vmid), .inv_asid(inv_asid)
    );
  end

  vtag_tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid_vec(valid_vec), .alloc(fill_take), .slot(slot)
  );

  // lowest-numbered hit wins when a small page sits inside a cached block
  always_comb begin
    hit_any  = 1'b0;
    sel_ppn  = '0;
    sel_big  = 1'b0;
    sel_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_any  = 1'b1;
        sel_ppn  = e_ppn[i];
        sel_big  = e_big[i];
        sel_perm = e_perm[i];
      end
    end
  end

  always_comb begin
    st_d    = st_q;
    rv_d    = 1'b0;
    pa_d    = pa_q;
    cause_d = cause_q;
    cap_en  = 1'b0;
    if (st_q == ST_IDLE) begin
      if (acc_fire && hit_any) begin
        rv_d    = 1'b1;
        pa_d    = make_pa(sel_ppn, sel_big, lk_va);
        cause_d = perm_cause(sel_perm, lk_acc);
      end else if (acc_fire) begin
        cap_en = 1'b1;
        st_d   = ST_WAIT;
      end
    end else if (fill_valid) begin
      rv_d    = 1'b1;
      pa_d    = make_pa(fill_ppn, fill_big, va_q);
      cause_d = perm_cause(fill_perm, acc_q);
      st_d    = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      rv_q    <= 1'b0;
      pa_q    <= '0;
      cause_q <= CAUSE_OK;
    end else begin
      st_q <= st_d;
      rv_q <= rv_d;
      if (rv_d) begin
        pa_q    <= pa_d;
        cause_q <= cause_d;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap_en) begin
      va_q   <= lk_va;
      asid_q <= lk_asid;
      vmid_q <= lk_vmid;
      acc_q  <= lk_acc;
    end
  end

  assign rsp_valid = rv_q;
  assign rsp_pa    = pa_q;
  assign rsp_cause = cause_q;
  assign rsp_fault = (cause_q != CAUSE_OK);
  assign walk_req  = (st_q == ST_WAIT);
  assign walk_va   = va_q;
  assign walk_asid = asid_q;
  assign walk_vmid = vmid_q;

  // R3: a walk starts only after an accepted lookup that missed
  a_r3_walk_after_miss: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(walk_req) |-> $past(acc_fire && !hit_any));

  // R10: a refill is answered in the next cycle and lookups reopen
  a_r10_fill_answered: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_req && fill_valid) |=> (rsp_valid && lk_ready));

  // R10: every answer is caused by a hit or a refill one cycle earlier
  a_r10_rsp_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(acc_fire && hit_any) || $past(walk_req && fill_valid)));

  // R9: invalidate-all leaves no live entry unless a refill lands at once
  a_r9_inv_all_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && inv_kind == INV_ALL && !fill_take) |=> (valid_vec == '0));

endmodule

// File: tb/vtag_tlb_bench.sv
module vtag_tlb_bench;

  typedef struct {
    logic [31:0] pa;
    logic [1:0]  cause;
    string       req;
  } exp_t;

  logic        clk, rst_n;
  logic        lk_valid, lk_ready;
  logic [31:0] lk_va;
  logic [7:0]  lk_asid;
  logic [3:0]  lk_vmid;
  logic [1:0]  lk_acc;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_pa;
  logic [1:0]  rsp_cause;
  logic        walk_req;
  logic [31:0] walk_va;
  logic [7:0]  walk_asid;
  logic [3:0]  walk_vmid;
  logic        fill_valid, fill_big;
  logic [19:0] fill_ppn;
  logic [2:0]  fill_perm_s1, fill_perm_s2;
  logic        inv_valid;
  logic [1:0]  inv_kind;
  logic [3:0]  inv_vmid;
  logic [7:0]  inv_asid;

  int   n_checks = 0;
  int   n_fail   = 0;
  exp_t sb_q[$];

  vtag_tlb u_vtag_tlb (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  // monitor: pop one expectation per answer
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R10", "unexpected answer", rsp_pa, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_pa == e.pa, e.req, "pa", rsp_pa, e.pa);
        chk(rsp_cause == e.cause, e.req, "cause", {30'd0, rsp_cause}, {30'd0, e.cause});
        chk(rsp_fault == (e.cause != 2'd0), e.req, "fault", {31'd0, rsp_fault},
            {31'd0, e.cause != 2'd0});
      end
    end
  end

  task automatic drive_req(input logic [31:0] va, input logic [7:0] asid,
                           input logic [3:0] vmid, input logic [1:0] acc);
    @(negedge clk);
    lk_valid = 1'b1; lk_va = va; lk_asid = asid; lk_vmid = vmid; lk_acc = acc;
    @(negedge clk);
    lk_valid = 1'b0;
  endtask

  task automatic look(input logic [31:0] va, input logic [7:0] asid, input logic [3:0] vmid,
                      input logic [1:0] acc, input logic [31:0] epa, input logic [1:0] ec,
                      input string r);
    sb_q.push_back('{pa: epa, cause: ec, req: r});
    drive_req(va, asid, vmid, acc);
    chk(walk_req == 1'b0, {r, "/R3"}, "walk on hit", {31'd0, walk_req}, 32'd0);
    chk(rsp_valid == 1'b1, {r, "/R10"}, "hit answer timing", {31'd0, rsp_valid}, 32'd1);
  endtask

  task automatic miss(input logic [31:0] va, input logic [7:0] asid, input logic [3:0] vmid,
                      input logic [1:0] acc, input logic [19:0] ppn, input logic big,
                      input logic [2:0] p1, input logic [2:0] p2,
                      input logic [31:0] epa, input logic [1:0] ec, input string r);
    sb_q.push_back('{pa: epa, cause: ec, req: r});
    drive_req(va, asid, vmid, acc);
    chk(walk_req == 1'b1, {r, "/R3"}, "walk_req", {31'd0, walk_req}, 32'd1);
    chk(walk_va == va, {r, "/R3"}, "walk_va", walk_va, va);
    chk(walk_asid == asid && walk_vmid == vmid, {r, "/R3"}, "walk tags",
        {20'd0, walk_vmid, walk_asid}, {20'd0, vmid, asid});
    chk(lk_ready == 1'b0, {r, "/R10"}, "stall", {31'd0, lk_ready}, 32'd0);
    @(negedge clk);
    chk(rsp_valid == 1'b0 && lk_ready == 1'b0, {r, "/R10"}, "idle while waiting",
        {30'd0, rsp_valid, lk_ready}, 32'd0);
    fill_valid = 1'b1; fill_ppn = ppn; fill_big = big;
    fill_perm_s1 = p1; fill_perm_s2 = p2;
    @(negedge clk);
    fill_valid = 1'b0;
    chk(lk_ready == 1'b1, {r, "/R10"}, "reopen after fill", {31'd0, lk_ready}, 32'd1);
  endtask

  task automatic inval(input logic [1:0] kind, input logic [3:0] vm, input logic [7:0] as);
    @(negedge clk);
    inv_valid = 1'b1; inv_kind = kind; inv_vmid = vm; inv_asid = as;
    @(negedge clk);
    inv_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; lk_valid = 1'b0; lk_va = '0; lk_asid = '0; lk_vmid = '0; lk_acc = '0;
    fill_valid = 1'b0; fill_ppn = '0; fill_big = 1'b0; fill_perm_s1 = '0; fill_perm_s2 = '0;
    inv_valid = 1'b0; inv_kind = '0; inv_vmid = '0; inv_asid = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(lk_ready == 1'b1 && walk_req == 1'b0 && rsp_valid == 1'b0, "R10", "reset state",
        {29'd0, lk_ready, walk_req, rsp_valid}, 32'd4);

    // R4 page translation, R1 process tag
    miss(32'h0000_1234, 8'd1, 4'd1, 2'd0, 20'h00055, 1'b0, 3'd7, 3'd7, 32'h0005_5234, 2'd0, "R4");
    look(32'h0000_1234, 8'd1, 4'd1, 2'd0, 32'h0005_5234, 2'd0, "R4");
    miss(32'h0000_1234, 8'd2, 4'd1, 2'd0, 20'h00066, 1'b0, 3'd7, 3'd7, 32'h0006_6234, 2'd0, "R1");
    look(32'h0000_1ABC, 8'd1, 4'd1, 2'd0, 32'h0005_5ABC, 2'd0, "R1");
    look(32'h0000_1ABC, 8'd2, 4'd1, 2'd0, 32'h0006_6ABC, 2'd0, "R1");
    // R2 guest tag
    miss(32'h0000_1234, 8'd1, 4'd2, 2'd0, 20'h00077, 1'b0, 3'd7, 3'd7, 32'h0007_7234, 2'd0, "R2");
    look(32'h0000_1234, 8'd1, 4'd1, 2'd0, 32'h0005_5234, 2'd0, "R2");
    // R7 2 MB block
    miss(32'h0041_2345, 8'd1, 4'd1, 2'd0, 20'h00A00, 1'b1, 3'd7, 3'd7, 32'h00A1_2345, 2'd0, "R7");
    look(32'h005F_FFFC, 8'd1, 4'd1, 2'd0, 32'h00BF_FFFC, 2'd0, "R7");
    miss(32'h0060_0010, 8'd1, 4'd1, 2'd0, 20'h00123, 1'b0, 3'd7, 3'd7, 32'h0012_3010, 2'd0, "R7");
    // R6 combined permissions, R5 causes
    miss(32'h0000_3000, 8'd3, 4'd1, 2'd1, 20'h00200, 1'b0, 3'b011, 3'b101, 32'h0020_0000, 2'd2, "R6");
    look(32'h0000_3004, 8'd3, 4'd1, 2'd0, 32'h0020_0004, 2'd0, "R6");
    look(32'h0000_3008, 8'd3, 4'd1, 2'd2, 32'h0020_0008, 2'd3, "R5");
    miss(32'h0000_4000, 8'd3, 4'd1, 2'd0, 20'h00300, 1'b0, 3'b100, 3'b111, 32'h0030_0000, 2'd1, "R5");
    look(32'h0000_4010, 8'd3, 4'd1, 2'd2, 32'h0030_0010, 2'd0, "R5");
    look(32'h0000_4010, 8'd3, 4'd1, 2'd1, 32'h0030_0010, 2'd2, "R5");
    // R9 invalidations
    inval(2'd2, 4'd1, 8'd2);
    miss(32'h0000_1234, 8'd2, 4'd1, 2'd0, 20'h00088, 1'b0, 3'd7, 3'd7, 32'h0008_8234, 2'd0, "R9");
    look(32'h0000_1234, 8'd1, 4'd1, 2'd0, 32'h0005_5234, 2'd0, "R9");
    inval(2'd1, 4'd2, 8'd0);
    miss(32'h0000_1234, 8'd1, 4'd2, 2'd0, 20'h00099, 1'b0, 3'd7, 3'd7, 32'h0009_9234, 2'd0, "R9");
    look(32'h0000_3004, 8'd3, 4'd1, 2'd0, 32'h0020_0004, 2'd0, "R9");
    inval(2'd0, 4'd0, 8'd0);
    miss(32'h0000_1234, 8'd1, 4'd1, 2'd0, 20'h00111, 1'b0, 3'd7, 3'd7, 32'h0011_1234, 2'd0, "R9");
    // R8 fill the array, then overrun it twice
    for (int i = 1; i < 8; i++) begin
      miss(32'h0001_0000 + 32'(i) * 32'h1000, 8'd1, 4'd1, 2'd0, 20'h00400 + 20'(i), 1'b0,
           3'd7, 3'd7, 32'h0040_0000 + 32'(i) * 32'h1000, 2'd0, "R8");
    end
    miss(32'h0002_0000, 8'd1, 4'd1, 2'd0, 20'h00500, 1'b0, 3'd7, 3'd7, 32'h0050_0000, 2'd0, "R8");
    look(32'h0001_1000, 8'd1, 4'd1, 2'd0, 32'h0040_1000, 2'd0, "R8");
    miss(32'h0000_1234, 8'd1, 4'd1, 2'd0, 20'h00111, 1'b0, 3'd7, 3'd7, 32'h0011_1234, 2'd0, "R8");
    look(32'h0001_2000, 8'd1, 4'd1, 2'd0, 32'h0040_2000, 2'd0, "R8");
    miss(32'h0001_1000, 8'd1, 4'd1, 2'd0, 20'h00401, 1'b0, 3'd7, 3'd7, 32'h0040_1000, 2'd0, "R8");

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R10", "answers outstanding", 32'(sb_q.size()), 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule